// File: doc/BRIEF.md
# Page translation and protection checker

This block sits between a processor's address generation and its memory port. On every access it takes a virtual address and a read/write flag, splits the address into a virtual page number and a 4 KB page offset, and looks the page number up in a small page table held in flip-flops. Each table entry holds a physical page number, a resident flag, a read-allowed bit and a write-allowed bit. One cycle later the block presents either the physical address (the translated page number with the untouched offset) or a fault with a cause code and the faulting virtual address.

The cause codes are separate so that the operating system can react differently. A page that is not resident can be loaded and the access retried, and the retry then succeeds. A rights violation or an address beyond the table ends the process, reported as a segmentation fault. The operating system fills and changes entries through a write port that only acts while the kernel-mode input is high.

The response side is a small state machine. Its states are ST_IDLE (no response this cycle), ST_MAPPED (a translation is presented) and ST_FAULTED (a fault is presented). The transitions are: any state goes to ST_MAPPED on a request whose lookup passes, to ST_FAULTED on a request whose lookup fails, and to ST_IDLE on a cycle with no request.

Top module: `page_xlate_guard`

## Requirements
- R1: After reset no response is presented (rsp_valid low) and every entry is non-resident, so any in-range access faults with cause 1.
- R2: A request accepted at a clock edge is answered on the outputs during the following cycle only; a cycle without a request leaves rsp_valid low in the next cycle.
- R3: An access that passes all checks sets rsp_ok, rsp_cause = 0, and rsp_pa = {entry physical page, req_va[11:0]}; the low 12 address bits pass through unchanged.
- R4: A virtual page number of 16 or more (any of req_va[19:16] set) faults with cause 3, whatever the table holds.
- R5: An in-range access to an entry whose resident flag is clear faults with cause 1, whatever its permission bits.
- R6: A resident entry faults with cause 2 on a read (req_wr = 0) when its read bit is clear, or on a write (req_wr = 1) when its write bit is clear.
- R7: On a fault rsp_fault is high, rsp_ok low, rsp_badva equals the request's virtual address and rsp_pa is 0; on success rsp_badva is 0.
- R8: A table write (tbl_we) loads entry tbl_idx only while kernel_mode is high; with kernel_mode low it changes no entry.
- R9: A lookup in the same cycle as a table write to the same entry sees the old entry; the new contents apply from the next request on.
- R10: After a cause-1 fault, marking the entry resident through the kernel write port and repeating the same access yields a successful translation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| kernel_mode | input | 1 | High when the processor runs in kernel mode |
| tbl_we | input | 1 | Table entry write request |
| tbl_idx | input | 4 | Entry to write |
| tbl_resident | input | 1 | New resident flag |
| tbl_rd_ok | input | 1 | New read-allowed bit |
| tbl_wr_ok | input | 1 | New write-allowed bit |
| tbl_ppn | input | 8 | New physical page number |
| req_valid | input | 1 | Access request this cycle |
| req_va | input | 20 | Virtual address of the access |
| req_wr | input | 1 | 1 = write access, 0 = read access |
| rsp_valid | output | 1 | A response is presented |
| rsp_ok | output | 1 | Translation succeeded |
| rsp_fault | output | 1 | Access faulted |
| rsp_cause | output | 2 | 0 none, 1 not resident, 2 rights violation, 3 address beyond table |
| rsp_pa | output | 20 | Physical address on success, else 0 |
| rsp_badva | output | 20 | Faulting virtual address on a fault, else 0 |

## Verification
A corrupted table entry shows on the very next access to that page as a wrong physical page or a wrong cause code, so the bench keeps its own copy of the table and compares every response against it. A response state machine stuck in the wrong state shows one cycle after the request as a missing or stale rsp_valid, or as rsp_ok and rsp_fault disagreeing with the cause. A write that slips past the kernel gate stays invisible until that entry is read, so the bench probes entries after user-mode writes and after writes that collide with a lookup.

// File: rtl/pxg_pkg.sv
package pxg_pkg;

    typedef enum logic [1:0] {
        CAUSE_NONE         = 2'd0,
        CAUSE_NOT_RESIDENT = 2'd1,
        CAUSE_PROTECT      = 2'd2,
        CAUSE_BAD_ADDR     = 2'd3
    } cause_e;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_MAPPED  = 2'd1,
        ST_FAULTED = 2'd2
    } rsp_state_e;

    // Field positions inside one packed table entry
    localparam int unsigned FLD_RES = 0;
    localparam int unsigned FLD_RD  = 1;
    localparam int unsigned FLD_WR  = 2;
    localparam int unsigned FLD_PPN = 3;

endpackage

// File: rtl/pxg_table.sv
module pxg_table #(
    parameter int unsigned IDX_W = 4,
    parameter int unsigned PPN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             kernel_mode,
    input  logic             wr_req,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [PPN_W+2:0] wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [PPN_W+2:0] rd_data
);
    localparam int unsigned ENTRIES = 1 << IDX_W;
    localparam int unsigned ENT_W   = PPN_W + 3;

    logic [ENTRIES-1:0][ENT_W-1:0] mem_q;
    logic [ENTRIES-1:0]            sel;
    logic                          wr_allowed;

    assign wr_allowed = wr_req && kernel_mode;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_sel
        assign sel[g] = wr_allowed && (wr_idx == IDX_W'(g));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_q <= '0;
        end else begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (sel[i]) begin
                    mem_q[i] <= wr_data;
                end
            end
        end
    end

    assign rd_data = mem_q[rd_idx];

    AST_USER_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !kernel_mode) |=> $stable(mem_q)) else $error("user write changed table"); // R8

    AST_KERNEL_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && kernel_mode) |=> (mem_q[$past(wr_idx)] == $past(wr_data))) else $error("kernel write lost"); // R8

    AST_RESET_EMPTY: assert property (@(posedge clk)
        $rose(rst_n) |-> (mem_q == '0)) else $error("table not cleared"); // R1

endmodule

// File: rtl/pxg_check.sv
module pxg_check
    import pxg_pkg::*;
#(
    parameter int unsigned VPN_W = 8,
    parameter int unsigned IDX_W = 4,
    parameter int unsigned PPN_W = 8
) (
    input  logic [VPN_W-1:0] vpn,
    input  logic             is_write,
    input  logic [PPN_W+2:0] entry,
    output logic [IDX_W-1:0] idx,
    output cause_e           cause,
    output logic [PPN_W-1:0] ppn
);
    logic in_range;
    logic resident;
    logic allowed;

    assign idx = vpn[IDX_W-1:0];

    if (VPN_W > IDX_W) begin : g_range
        assign in_range = ~|vpn[VPN_W-1:IDX_W];
    end else begin : g_full
        assign in_range = 1'b1;
    end

    assign resident = entry[FLD_RES];
    assign allowed  = is_write ? entry[FLD_WR] : entry[FLD_RD];
    assign ppn      = entry[FLD_PPN +: PPN_W];

    // Order of checks: address range, then residency, then rights
    always_comb begin
        if (!in_range) begin
            cause = CAUSE_BAD_ADDR;
        end else if (!resident) begin
            cause = CAUSE_NOT_RESIDENT;
        end else if (!allowed) begin
            cause = CAUSE_PROTECT;
        end else begin
            cause = CAUSE_NONE;
        end
    end

endmodule

// File: rtl/page_xlate_guard.sv
module page_xlate_guard
    import pxg_pkg::*;
#(
    parameter int unsigned VA_W  = 20,
    parameter int unsigned PA_W  = 20,
    parameter int unsigned OFF_W = 12,
    parameter int unsigned IDX_W = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  kernel_mode,
    input  logic                  tbl_we,
    input  logic [IDX_W-1:0]      tbl_idx,
    input  logic                  tbl_resident,
    input  logic                  tbl_rd_ok,
    input  logic                  tbl_wr_ok,
    input  logic [PA_W-OFF_W-1:0] tbl_ppn,
    input  logic                  req_valid,
    input  logic [VA_W-1:0]       req_va,
    input  logic                  req_wr,
    output logic                  rsp_valid,
    output logic                  rsp_ok,
    output logic                  rsp_fault,
    output logic [1:0]            rsp_cause,
    output logic [PA_W-1:0]       rsp_pa,
    output logic [VA_W-1:0]       rsp_badva
);
    localparam int unsigned VPN_W = VA_W - OFF_W;
    localparam int unsigned PPN_W = PA_W - OFF_W;
    localparam int unsigned ENT_W = PPN_W + 3;

    rsp_state_e        state_q, state_d;
    logic [ENT_W-1:0]  wr_data;
    logic [ENT_W-1:0]  rd_entry;
    logic [IDX_W-1:0]  rd_idx;
    cause_e            lookup_cause;
    logic [PPN_W-1:0]  lookup_ppn;
    logic [PA_W-1:0]   pa_q;
    logic [VA_W-1:0]   va_q;
    cause_e            cause_q;

    always_comb begin
        wr_data                     = '0;
        wr_data[FLD_RES]            = tbl_resident;
        wr_data[FLD_RD]             = tbl_rd_ok;
        wr_data[FLD_WR]             = tbl_wr_ok;
        wr_data[FLD_PPN +: PPN_W]   = tbl_ppn;
    end

    pxg_table #(
        .IDX_W (IDX_W),
        .PPN_W (PPN_W)
    ) u_table (
        .clk         (clk),
        .rst_n       (rst_n),
        .kernel_mode (kernel_mode),
        .wr_req      (tbl_we),
        .wr_idx      (tbl_idx),
        .wr_data     (wr_data),
        .rd_idx      (rd_idx),
        .rd_data     (rd_entry)
    );

    pxg_check #(
        .VPN_W (VPN_W),
        .IDX_W (IDX_W),
        .PPN_W (PPN_W)
    ) u_check (
        .vpn      (req_va[VA_W-1:OFF_W]),
        .is_write (req_wr),
        .entry    (rd_entry),
        .idx      (rd_idx),
        .cause    (lookup_cause),
        .ppn      (lookup_ppn)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_MAPPED, ST_FAULTED: begin
                if (!req_valid) begin
                    state_d = ST_IDLE;
                end else if (lookup_cause == CAUSE_NONE) begin
                    state_d = ST_MAPPED;
                end else begin
                    state_d = ST_FAULTED;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Result capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pa_q    <= '0;
            va_q    <= '0;
            cause_q <= CAUSE_NONE;
        end else if (req_valid) begin
            pa_q    <= {lookup_ppn, req_va[OFF_W-1:0]};
            va_q    <= req_va;
            cause_q <= lookup_cause;
        end
    end

    // Outputs decoded from the state
    always_comb begin
        rsp_valid = 1'b0;
        rsp_ok    = 1'b0;
        rsp_fault = 1'b0;
        rsp_cause = CAUSE_NONE;
        rsp_pa    = '0;
        rsp_badva = '0;
        unique case (state_q)
            ST_IDLE: begin
            end
            ST_MAPPED: begin
                rsp_valid = 1'b1;
                rsp_ok    = 1'b1;
                rsp_pa    = pa_q;
            end
            ST_FAULTED: begin
                rsp_valid = 1'b1;
                rsp_fault = 1'b1;
                rsp_cause = cause_q;
                rsp_badva = va_q;
            end
            default: begin
            end
        endcase
    end

    AST_RESP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid) else $error("missing response"); // R2

    AST_NO_SPURIOUS_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid) else $error("response without request"); // R2

    AST_OFFSET_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_ok |-> (rsp_pa[OFF_W-1:0] == $past(req_va[OFF_W-1:0]))) else $error("offset altered"); // R3

    AST_OK_XOR_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_ok != rsp_fault)) else $error("ok and fault disagree"); // R7

    AST_FAULT_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> (rsp_cause != 2'd0)) else $error("fault without cause"); // R7

    AST_BADVA_CAPTURED: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> (rsp_badva == $past(req_va))) else $error("wrong faulting address"); // R7

    AST_HIGH_VPN_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_va[VA_W-1:OFF_W+IDX_W] != '0)) |=> (rsp_cause == 2'd3)) else $error("out-of-table access not flagged"); // R4

endmodule

// File: tb/test_page_xlate_guard.sv
module test_page_xlate_guard;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        kernel_mode;
    logic        tbl_we;
    logic [3:0]  tbl_idx;
    logic        tbl_resident, tbl_rd_ok, tbl_wr_ok;
    logic [7:0]  tbl_ppn;
    logic        req_valid;
    logic [19:0] req_va;
    logic        req_wr;
    logic        rsp_valid, rsp_ok, rsp_fault;
    logic [1:0]  rsp_cause;
    logic [19:0] rsp_pa, rsp_badva;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    // Bench copy of the table
    bit       m_res [16];
    bit       m_rd  [16];
    bit       m_wr  [16];
    bit [7:0] m_ppn [16];

    always #2.5 clk = ~clk;

    page_xlate_guard i_page_xlate_guard (
        .clk, .rst_n, .kernel_mode, .tbl_we, .tbl_idx, .tbl_resident,
        .tbl_rd_ok, .tbl_wr_ok, .tbl_ppn, .req_valid, .req_va, .req_wr,
        .rsp_valid, .rsp_ok, .rsp_fault, .rsp_cause, .rsp_pa, .rsp_badva
    );

    function automatic logic [1:0] exp_cause(input logic [19:0] va, input logic wr);
        logic [3:0] ix;
        ix = va[15:12];
        if (va[19:16] != 4'd0)                return 2'd3;
        if (!m_res[ix])                       return 2'd1;
        if (wr ? !m_wr[ix] : !m_rd[ix])       return 2'd2;
        return 2'd0;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_write(input logic [3:0] ix, input bit r, input bit rd, input bit w, input logic [7:0] p);
        m_res[ix] = r; m_rd[ix] = rd; m_wr[ix] = w; m_ppn[ix] = p;
    endtask

    // Entered and left at a falling edge
    task automatic tbl_write(input bit kern, input logic [3:0] ix, input bit r, input bit rd, input bit w, input logic [7:0] p);
        kernel_mode = kern; tbl_we = 1'b1; tbl_idx = ix;
        tbl_resident = r; tbl_rd_ok = rd; tbl_wr_ok = w; tbl_ppn = p;
        @(negedge clk);
        tbl_we = 1'b0;
        if (kern) model_write(ix, r, rd, w, p);
    endtask

    task automatic check_rsp(input string tag, input logic [19:0] va, input logic [1:0] ec, input logic [19:0] epa);
        chk({tag, " valid"}, 32'(rsp_valid), 32'd1);
        chk({tag, " cause"}, 32'(rsp_cause), 32'(ec));
        chk({tag, " ok"},    32'(rsp_ok),    32'(ec == 2'd0));
        chk({tag, " fault"}, 32'(rsp_fault), 32'(ec != 2'd0));
        chk({tag, " pa"},    32'(rsp_pa),    (ec == 2'd0) ? 32'(epa) : 32'd0);
        chk({tag, " badva"}, 32'(rsp_badva), (ec != 2'd0) ? 32'(va) : 32'd0);
    endtask

    task automatic access(input string tag, input logic [19:0] va, input logic wr);
        logic [1:0]  ec;
        logic [19:0] epa;
        ec  = exp_cause(va, wr);
        epa = {m_ppn[va[15:12]], va[11:0]};
        req_valid = 1'b1; req_va = va; req_wr = wr;
        @(negedge clk);
        req_valid = 1'b0;
        check_rsp(tag, va, ec, epa);
    endtask

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                tests++; fails++;
                $display("FAIL watchdog expired");
                $display("[TB] %0d tests run, %0d failed", tests, fails);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < 16; i++) model_write(4'(i), 1'b0, 1'b0, 1'b0, 8'h00);
        rst_n = 1'b0; kernel_mode = 1'b0; tbl_we = 1'b0; tbl_idx = '0;
        tbl_resident = 1'b0; tbl_rd_ok = 1'b0; tbl_wr_ok = 1'b0; tbl_ppn = '0;
        req_valid = 1'b0; req_va = '0; req_wr = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: nothing presented, empty table faults as not resident
        chk("R1 idle after reset", 32'(rsp_valid), 32'd0);
        access("R1 empty table", 20'h0_3abc, 1'b0);
        access("R1 empty table top", 20'h0_F001, 1'b1);

        // R2: a cycle with no request drops rsp_valid
        @(negedge clk);
        chk("R2 no request no response", 32'(rsp_valid), 32'd0);

        // R3: plain translations
        tbl_write(1'b1, 4'd2, 1'b1, 1'b1, 1'b1, 8'hA5);
        access("R3 read map", 20'h0_2123, 1'b0);
        access("R3 write map", 20'h0_2FFF, 1'b1);
        access("R3 offset zero", 20'h0_2000, 1'b0);

        // R4: beyond table, even with a valid low index
        access("R4 bad address", 20'h1_2123, 1'b0);
        access("R4 bad address top", 20'hF_FFFF, 1'b1);

        // R5: not resident wins over missing rights
        tbl_write(1'b1, 4'd5, 1'b0, 1'b1, 1'b1, 8'h11);
        access("R5 not resident", 20'h0_5010, 1'b0);
        tbl_write(1'b1, 4'd6, 1'b0, 1'b0, 1'b0, 8'h22);
        access("R5 not resident no rights", 20'h0_6010, 1'b1);

        // R6: rights
        tbl_write(1'b1, 4'd7, 1'b1, 1'b1, 1'b0, 8'h33);
        access("R6 write to read-only", 20'h0_7444, 1'b1);
        access("R6 read read-only", 20'h0_7444, 1'b0);
        tbl_write(1'b1, 4'd8, 1'b1, 1'b0, 1'b1, 8'h44);
        access("R6 read from write-only", 20'h0_8004, 1'b0);
        access("R6 write write-only", 20'h0_8004, 1'b1);

        // R7: back-to-back fault then success clears badva
        access("R7 fault", 20'h0_9ABC, 1'b0);
        access("R7 success after fault", 20'h0_2ABC, 1'b0);

        // R8: user-mode write ignored, checked by reading the entry back
        tbl_write(1'b0, 4'd2, 1'b0, 1'b0, 1'b0, 8'hFF);
        access("R8 user write ignored", 20'h0_2555, 1'b1);
        tbl_write(1'b0, 4'd9, 1'b1, 1'b1, 1'b1, 8'h99);
        access("R8 user write no map", 20'h0_9555, 1'b0);

        // R9: write and lookup together on the same entry
        begin
            logic [1:0]  ec;
            logic [19:0] epa;
            ec  = exp_cause(20'h0_7100, 1'b1);
            epa = {m_ppn[7], 12'h100};
            kernel_mode = 1'b1; tbl_we = 1'b1; tbl_idx = 4'd7;
            tbl_resident = 1'b1; tbl_rd_ok = 1'b1; tbl_wr_ok = 1'b1; tbl_ppn = 8'h77;
            req_valid = 1'b1; req_va = 20'h0_7100; req_wr = 1'b1;
            @(negedge clk);
            tbl_we = 1'b0; req_valid = 1'b0;
            check_rsp("R9 same-cycle old entry", 20'h0_7100, ec, epa);
            model_write(4'd7, 1'b1, 1'b1, 1'b1, 8'h77);
            access("R9 new entry next", 20'h0_7100, 1'b1);
        end

        // R10: page fault, load page, retry succeeds
        access("R10 first try", 20'h0_C321, 1'b1);
        tbl_write(1'b1, 4'd12, 1'b1, 1'b1, 1'b1, 8'hC0);
        access("R10 retry", 20'h0_C321, 1'b1);

        // Random mix against the bench model
        for (int n = 0; n < 400; n++) begin
            int unsigned sel;
            sel = $urandom_range(0, 9);
            if (sel < 3) begin
                tbl_write(($urandom_range(0, 3) != 0), 4'($urandom_range(0, 15)),
                          1'($urandom), 1'($urandom), 1'($urandom), 8'($urandom));
            end else if (sel == 3) begin
                @(negedge clk);
                chk("R2 random idle", 32'(rsp_valid), 32'd0);
            end else begin
                access("R3/R4/R5/R6 random",
                       {4'(($urandom_range(0, 19) >= 16) ? $urandom_range(1, 15) : 0),
                        4'($urandom_range(0, 15)), 12'($urandom)},
                       1'($urandom));
            end
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule